// File: doc/BRIEF.md
# Ping-Pong Complex Sample Frame Buffer

This block collects complex samples from two converter channels that sample at the same instant. One channel gives the real part and the other gives the imaginary part, each 12 bits wide. The block groups the samples into frames of 256. All storage is one single-ported memory of 512 words by 36 bits. The memory is split into two banks of 256 words, and the banks swap roles at every frame boundary. While one bank fills with new samples, the downstream transform engine reads the previous frame from the other bank, one sample per request. Capture never pauses.

The memory clock runs at three times the sample rate. A three-state slot sequencer repeats the order SLOT_WR → SLOT_RD_A → SLOT_RD_B → SLOT_WR. The memory port is used as follows:

- In SLOT_WR the newest captured sample is written.
- The two read states serve consumer requests.

A two-state read arbiter handles requests that arrive during SLOT_WR:

- ARB_EMPTY → ARB_HELD: a request arrives in SLOT_WR and its address is parked.
- ARB_HELD → ARB_EMPTY: the parked address is served in the next read slot and no new request arrives in that cycle.
- ARB_HELD stays in ARB_HELD: a new request arrives in the same read cycle that serves the parked one.

When a bank receives its 256th sample, the block raises a one-cycle frame-ready pulse that names that bank. From then on, reads go to that bank. An overrun flag records that a bank was filled again before the consumer had read its last address.

Top module: `cfp_frame_pingpong`

## Requirements
- R1: Each stored word holds the real part in bits [11:0], the imaginary part in bits [23:12], and zero in bits [35:24]. A read returns that word unchanged.
- R2: Every sample presented with `smp_valid` is stored, with none lost. Sample n of a frame is stored at address n of its bank. The source presents at most one sample every three clock cycles.
- R3: After the 256th sample of a bank is written, `frame_ready` is high for exactly one cycle. `frame_bank` gives that bank. Frames alternate between banks, starting with bank 0.
- R4: Reads address the bank that completed most recently, while capture continues into the other bank.
- R5: The slot order after reset is SLOT_WR, SLOT_RD_A, SLOT_RD_B, repeating. The memory is written only in SLOT_WR and is never written and read in the same cycle.
- R6: A request made in a read slot returns `rd_valid` and data one cycle later. A request made in SLOT_WR returns them two cycles later. Results come back in request order. The consumer issues no requests in two consecutive cycles.
- R7: `overrun` is set when a bank completes while the previous frame in that bank has not had address 255 read. Once set, it stays set until reset.
- R8: During and right after reset, `rd_valid`, `rd_data`, `frame_ready`, `frame_bank` and `overrun` are all zero.
- R9: `rd_valid` is never high in a cycle that does not follow a served request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, three times the sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A new sample is present |
| smp_re | input | 12 | Real part (first channel) |
| smp_im | input | 12 | Imaginary part (second channel) |
| rd_req | input | 1 | Consumer read request |
| rd_addr | input | 8 | Sample index inside the completed frame |
| rd_valid | output | 1 | `rd_data` holds a returned word |
| rd_data | output | 36 | Returned memory word |
| frame_ready | output | 1 | One-cycle pulse when a bank completes |
| frame_bank | output | 1 | Bank that has just completed |
| overrun | output | 1 | Sticky flag: a bank was refilled before it was fully read |

## Verification
The hardest state to reach is a read request that lands exactly in SLOT_WR and is therefore parked, while capture keeps writing at full rate. The bench reaches it by randomising the gap between requests, so the phase of each request relative to the slot sequencer drifts, and by predicting the latency from its own model of that phase. The overrun path needs a bank to come round again while still unread. Directed frame handling reaches it: frames 0, 1 and 3 are read completely, frame 2 is skipped, and so frame 4 must raise the flag while frame 3 must not.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
    typedef enum logic [1:0] {
        SLOT_WR   = 2'd0,
        SLOT_RD_A = 2'd1,
        SLOT_RD_B = 2'd2
    } slot_e;

    typedef enum logic {
        ARB_EMPTY = 1'b0,
        ARB_HELD  = 1'b1
    } arb_e;
endpackage

// File: rtl/cfp_slot_seq.sv
module cfp_slot_seq
    import cfp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output slot_e slot
);
    slot_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_WR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_WR:   state_d = SLOT_RD_A;
            SLOT_RD_A: state_d = SLOT_RD_B;
            SLOT_RD_B: state_d = SLOT_WR;
            default:   state_d = SLOT_WR;
        endcase
    end

    assign slot = state_q;

    assert_slot_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_WR) |=> (slot == SLOT_RD_A));
endmodule

// File: rtl/cfp_rd_arb.sv
module cfp_rd_arb
    import cfp_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  slot_e         slot,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    output logic          go,
    output logic [AW-1:0] go_addr
);
    arb_e          state_q, state_d;
    logic [AW-1:0] park_q, park_d;
    logic          rd_slot;

    assign rd_slot = (slot != SLOT_WR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_EMPTY;
            park_q  <= '0;
        end else begin
            state_q <= state_d;
            park_q  <= park_d;
        end
    end

    always_comb begin
        state_d = state_q;
        park_d  = park_q;
        go      = 1'b0;
        go_addr = rd_addr;
        unique case (state_q)
            ARB_EMPTY: begin
                if (rd_req && !rd_slot) begin
                    state_d = ARB_HELD;
                    park_d  = rd_addr;
                end else if (rd_req) begin
                    go = 1'b1;
                end
            end
            ARB_HELD: begin
                if (rd_slot) begin
                    go      = 1'b1;
                    go_addr = park_q;
                    if (rd_req) park_d = rd_addr;
                    else        state_d = ARB_EMPTY;
                end else if (rd_req) begin
                    park_d = rd_addr;
                end
            end
            default: state_d = ARB_EMPTY;
        endcase
    end

    assert_served_in_rd_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_HELD && slot != SLOT_WR) |-> go);
endmodule

// File: rtl/cfp_wr_ctrl.sv
module cfp_wr_ctrl
    import cfp_pkg::*;
#(
    parameter int SMP_W  = 12,
    parameter int WORD_W = 36,
    parameter int AW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slot_e             slot,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_re,
    input  logic [SMP_W-1:0]  smp_im,
    input  logic              clr_en,
    input  logic              clr_bank,
    output logic              we,
    output logic [AW-1:0]     wptr,
    output logic [WORD_W-1:0] wdata,
    output logic              wbank,
    output logic              frame_ready,
    output logic              frame_bank,
    output logic              overrun
);
    localparam int PAD = WORD_W - 2*SMP_W;

    logic               hold_v;
    logic [2*SMP_W-1:0] hold_d;
    logic [1:0]         pend;
    logic               last;

    assign we    = hold_v && (slot == SLOT_WR);
    assign wdata = {{PAD{1'b0}}, hold_d};
    assign last  = we && (wptr == {AW{1'b1}});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v      <= 1'b0;
            hold_d      <= '0;
            wptr        <= '0;
            wbank       <= 1'b0;
            frame_ready <= 1'b0;
            frame_bank  <= 1'b0;
            overrun     <= 1'b0;
            pend        <= '0;
        end else begin
            if (smp_valid) begin
                hold_v <= 1'b1;
                hold_d <= {smp_im, smp_re};
            end else if (we) begin
                hold_v <= 1'b0;
            end
            if (we) wptr <= wptr + 1'b1;
            frame_ready <= last;
            if (last) begin
                wbank      <= ~wbank;
                frame_bank <= wbank;
                if (pend[wbank]) overrun <= 1'b1;
            end
            for (int b = 0; b < 2; b++) begin
                if (last && (wbank == b[0]))             pend[b] <= 1'b1;
                else if (clr_en && (clr_bank == b[0]))   pend[b] <= 1'b0;
            end
        end
    end

    assert_write_in_wr_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (slot == SLOT_WR));
    assert_ready_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ready |=> !frame_ready);
    assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    assert_bank_swaps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ready |-> (wbank != frame_bank));
endmodule

// File: rtl/cfp_frame_pingpong.sv
module cfp_frame_pingpong
    import cfp_pkg::*;
#(
    parameter int SMP_W     = 12,
    parameter int WORD_W    = 36,
    parameter int FRAME_LEN = 256,
    localparam int AW       = $clog2(FRAME_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_re,
    input  logic [SMP_W-1:0]  smp_im,
    input  logic              rd_req,
    input  logic [AW-1:0]     rd_addr,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              frame_ready,
    output logic              frame_bank,
    output logic              overrun
);
    localparam int DEPTH = 2 * FRAME_LEN;

    slot_e             slot;
    logic              we, wbank, go;
    logic [AW-1:0]     wptr, go_addr;
    logic [WORD_W-1:0] wdata;
    logic [AW:0]       port_addr;
    logic              clr_en;
    logic [WORD_W-1:0] mem [DEPTH];

    cfp_slot_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .slot  (slot)
    );

    cfp_rd_arb #(.AW(AW)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .slot    (slot),
        .rd_req  (rd_req),
        .rd_addr (rd_addr),
        .go      (go),
        .go_addr (go_addr)
    );

    assign clr_en = go && (go_addr == {AW{1'b1}});

    cfp_wr_ctrl #(.SMP_W(SMP_W), .WORD_W(WORD_W), .AW(AW)) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot        (slot),
        .smp_valid   (smp_valid),
        .smp_re      (smp_re),
        .smp_im      (smp_im),
        .clr_en      (clr_en),
        .clr_bank    (~wbank),
        .we          (we),
        .wptr        (wptr),
        .wdata       (wdata),
        .wbank       (wbank),
        .frame_ready (frame_ready),
        .frame_bank  (frame_bank),
        .overrun     (overrun)
    );

    // single port: one address per cycle, write side wins by slot design
    assign port_addr = we ? {wbank, wptr} : {~wbank, go_addr};

    always_ff @(posedge clk) begin
        if (we) mem[port_addr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= go && !we;
            if (go && !we) rd_data <= mem[port_addr];
        end
    end

    assert_port_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && go));
    assert_valid_after_rd_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(slot) != SLOT_WR));
endmodule

// File: tb/test_cfp_frame_pingpong.sv
`timescale 1ns/1ps
module test_cfp_frame_pingpong;
    localparam int FL   = 256;
    localparam int NCYC = 3950;

    logic        clk = 1'b0;
    logic        rst_n, smp_valid, rd_req;
    logic [11:0] smp_re, smp_im;
    logic [7:0]  rd_addr;
    logic        rd_valid, frame_ready, frame_bank, overrun;
    logic [35:0] rd_data;

    always #2.5 clk = ~clk;

    cfp_frame_pingpong i_cfp_frame_pingpong (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_re(smp_re),
        .smp_im(smp_im), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_data(rd_data), .frame_ready(frame_ready), .frame_bank(frame_bank),
        .overrun(overrun)
    );

    int errs = 0, checks = 0;
    bit done = 0;
    logic [23:0] model [2][FL];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] word_of(input logic [23:0] s);
        return {12'h000, s};
    endfunction

    initial begin
        int ph, sent, frames, smp_off, rd_i, rd_wait, mul, ofs;
        bit rd_on, p0v, p1v;
        logic [35:0] p0d, p1d;
        logic [7:0] a;
        int rb;
        void'($urandom(32'h1234abcd));
        sent = 0; frames = 0; rd_on = 0; p0v = 0; p1v = 0; p0d = '0; p1d = '0;
        rd_i = 0; rd_wait = 0; mul = 1; ofs = 0; rb = 0;
        rst_n = 0; smp_valid = 0; smp_re = '0; smp_im = '0; rd_req = 0; rd_addr = '0;
        repeat (4) @(negedge clk);
        // R8: reset state
        chk(rd_valid == 0 && frame_ready == 0 && overrun == 0, "R8 flags", {rd_valid, frame_ready, overrun}, 0);
        chk(rd_data == 0 && frame_bank == 0, "R8 data", rd_data, 0);
        rst_n = 1;
        ph = 0;
        smp_off = $urandom % 3;
        for (int cyc = 0; cyc < NCYC; cyc++) begin
            // capture stimulus: constant rate, one sample per three cycles
            smp_valid = (cyc % 3 == smp_off);
            if (smp_valid) begin
                smp_re = 12'($urandom);
                smp_im = 12'($urandom);
                model[(sent / FL) % 2][sent % FL] = {smp_im, smp_re};
                sent++;
            end
            // consumer stimulus
            rd_req = 0;
            if (rd_on) begin
                if (rd_wait > 0) rd_wait--;
                else begin
                    a = 8'((rd_i * mul + ofs) & 255);
                    rd_req = 1; rd_addr = a;
                    if (ph != 0) begin p0v = 1; p0d = word_of(model[rb][a]); end
                    else         begin p1v = 1; p1d = word_of(model[rb][a]); end
                    rd_i++;
                    rd_wait = 1 + (($urandom % 4) == 0 ? 1 : 0);
                    if (rd_i == FL) rd_on = 0;
                end
            end
            @(negedge clk);
            // R6/R9: latency, order and no spurious valid
            chk(rd_valid == p0v, "R6 R9 rd_valid timing", rd_valid, p0v);
            if (p0v && rd_valid)
                chk(rd_data == p0d, "R1 R2 R4 read word", rd_data, p0d);
            p0v = p1v; p0d = p1d; p1v = 0;
            ph = (ph + 1) % 3;
            if (frame_ready) begin
                chk(frame_bank == 1'(frames % 2), "R3 frame bank", frame_bank, frames % 2);
                chk(sent >= FL * (frames + 1) && sent <= FL * (frames + 1) + 2,
                    "R3 pulse after 256th sample", sent, FL * (frames + 1));
                chk(overrun == (frames >= 4), "R7 overrun at completion", overrun, frames >= 4);
                if (frames != 2) begin
                    rd_on = 1; rb = frames % 2; rd_i = 0;
                    rd_wait = $urandom % 3;
                    mul = 2 * ($urandom % 64) + 1;
                    ofs = $urandom % 256;
                end
                frames++;
            end
        end
        smp_valid = 0; rd_req = 0;
        repeat (6) @(negedge clk);
        chk(frames == 5, "R3 pulse count", frames, 5);
        chk(overrun == 1, "R7 overrun sticky", overrun, 1);
        chk(rd_valid == 0, "R9 idle valid", rd_valid, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule